// File: doc/BRIEF.md
# Byte-Copy DMA Engine with Live Progress Registers

This block copies a run of configuration bytes from an upstream byte source into system memory. Software loads a 64-bit destination address, split over two 32-bit registers, and a 32-bit byte count. It then writes the control register to start the copy. The engine moves one byte per accepted memory beat. Each beat takes the current source byte and writes it to the current destination address. The destination and count registers advance in place as bytes land, so their values always show how far the copy has got.

The register window is 16 bytes. Only full, aligned 32-bit accesses are honoured. Register values cross the bus in big-endian byte order. Software reads the control register for status. Zero means finished. The error bit set means the memory side refused an address, and the engine stopped at that byte. The value with only the start bit set means the copy is still running.

Top module: `cfgdma_engine`

## Requirements
- R1: After reset the address, length and control registers all read as zero and `mem_req` is low.
- R2: An access counts only when `bus_off[1:0]` is 0 and `bus_be` is 4'hF. A write that fails this test changes nothing, and a read that fails it returns zero.
- R3: Register data is big-endian on the bus. Register bits [7:0] travel on `bus_wdata[31:24]` / `bus_rdata[31:24]`, and register bits [31:24] travel on lane [7:0].
- R4: Offset 0 holds destination bits [31:0] and offset 4 holds bits [63:32]. A write to either half leaves the other half unchanged. A read returns exactly the last value written to that half.
- R5: Offset 12 is control, with bit 0 = error and bit 1 = start. A written value is masked to bits [1:0] before it is stored. A copy begins only when the masked value is 2'b10.
- R6: While copying, `mem_req` stays high with `mem_addr` equal to the destination register and `mem_wdata` equal to `src_data`. On a beat with `mem_ack` high and `mem_err` low, `src_take` pulses, the destination register rises by one and the length register (offset 8) falls by one.
- R7: When the length reaches zero with no error, control clears to 0 and `mem_req` drops. Length then reads 0 and the destination points just past the last byte written.
- R8: `mem_err` during a copy sets the error bit, giving control 2'b11, and stops the copy. It has priority over `mem_ack`. Destination and length keep the values they held before that beat.
- R9: While a copy runs, control reads 2'b10 and every register write is ignored.
- R10: Starting with a length of zero finishes at once. Control reads 0 and no memory request is made.
- R11: A masked control value of 2'b01 or 2'b11 is stored as written and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_off | input | 4 | Byte offset within the 16-byte window |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Big-endian write data |
| bus_rdata | output | 32 | Big-endian read data, valid in the access cycle |
| src_data | input | 8 | Current byte offered by the configuration source |
| src_take | output | 1 | Pulse: current source byte consumed |
| mem_req | output | 1 | Memory write request, held until a response |
| mem_addr | output | 64 | Byte address of the request |
| mem_wdata | output | 8 | Byte to be written |
| mem_ack | input | 1 | Memory accepted the byte |
| mem_err | input | 1 | Memory rejected the address |

## Verification
The hardest situation to reach is an address rejection partway through a copy, followed by a resume from the stopped point. The bench's memory responder refuses every address at or above a movable limit. The limit is placed a few bytes past the start of a copy, so the engine stops with partial progress. The bench then checks the frozen address and length, writes error-bit control values that must not restart anything, lifts the limit and restarts. It also holds acknowledges back for several cycles, so register reads and ignored writes land while a copy is in flight.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
    localparam int REG_W   = 32;
    localparam int LANES   = REG_W / 8;
    localparam int ADDR_W  = 2 * REG_W;
    localparam int LEN_W   = REG_W;
    localparam int CTL_W   = 2;
    localparam int OFF_W   = 4;

    localparam int CTL_ERR_BIT = 0;
    localparam int CTL_RUN_BIT = 1;
    localparam logic [CTL_W-1:0] CTL_GO = 2'b10;

    typedef enum logic [1:0] {
        SLOT_DST_LO = 2'd0,
        SLOT_DST_HI = 2'd1,
        SLOT_COUNT  = 2'd2,
        SLOT_CTRL   = 2'd3
    } slot_e;

    typedef struct packed {
        logic             en;
        slot_e            slot;
        logic [REG_W-1:0] val;
    } reg_wr_t;
endpackage

// File: rtl/cfgdma_bus_decode.sv
module cfgdma_bus_decode
    import cfgdma_pkg::*;
(
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic [LANES-1:0]  bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [ADDR_W-1:0] dst,
    input  logic [LEN_W-1:0]  count,
    input  logic [CTL_W-1:0]  ctrl,
    output reg_wr_t           wr,
    output logic [REG_W-1:0]  bus_rdata
);
    logic             accept;
    logic             rd_ok;
    logic [REG_W-1:0] rd_sel;
    logic [REG_W-1:0] wr_swapped;
    logic [REG_W-1:0] rd_swapped;

    assign accept = bus_valid && (bus_off[1:0] == 2'b00) && (bus_be == '1);
    assign rd_ok  = accept && !bus_write;

    always_comb begin
        case (slot_e'(bus_off[3:2]))
            SLOT_DST_LO: rd_sel = dst[REG_W-1:0];
            SLOT_DST_HI: rd_sel = dst[ADDR_W-1:REG_W];
            SLOT_COUNT:  rd_sel = count;
            default:     rd_sel = {{(REG_W-CTL_W){1'b0}}, ctrl};
        endcase
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign wr_swapped[8*b +: 8] = bus_wdata[8*(LANES-1-b) +: 8];
        assign rd_swapped[8*b +: 8] = rd_sel[8*(LANES-1-b) +: 8];
    end

    assign wr.en     = accept && bus_write;
    assign wr.slot   = slot_e'(bus_off[3:2]);
    assign wr.val    = wr_swapped;
    assign bus_rdata = rd_ok ? rd_swapped : '0;
endmodule

// File: rtl/cfgdma_regfile.sv
module cfgdma_regfile
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr,
    input  logic              busy,
    input  logic              step,
    input  logic              fail,
    output logic [ADDR_W-1:0] dst,
    output logic [LEN_W-1:0]  count,
    output logic [CTL_W-1:0]  ctrl,
    output logic              start,
    output logic              last
);
    logic             wr_ok;
    logic [CTL_W-1:0] ctl_val;

    assign wr_ok   = wr.en && !busy;
    assign ctl_val = wr.val[CTL_W-1:0];
    assign start   = wr_ok && (wr.slot == SLOT_CTRL) && (ctl_val == CTL_GO) && (count != '0);
    assign last    = (count == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            dst   <= '0;
            count <= '0;
            ctrl  <= '0;
        end else begin
            if (wr_ok) begin
                case (wr.slot)
                    SLOT_DST_LO: dst[REG_W-1:0]      <= wr.val;
                    SLOT_DST_HI: dst[ADDR_W-1:REG_W] <= wr.val;
                    SLOT_COUNT:  count               <= wr.val;
                    default:     ctrl <= (ctl_val == CTL_GO && count == '0) ? '0 : ctl_val;
                endcase
            end
            if (step) begin
                dst   <= dst + ADDR_W'(1);
                count <= count - LEN_W'(1);
                if (last) ctrl <= '0;
            end
            if (fail) ctrl[CTL_ERR_BIT] <= 1'b1;
        end
    end

    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        step |=> (dst == $past(dst) + ADDR_W'(1)) && (count == $past(count) - LEN_W'(1)));

    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        fail |=> ctrl[CTL_ERR_BIT] && (dst == $past(dst)) && (count == $past(count)));

    p_empty_start_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && wr.slot == SLOT_CTRL && ctl_val == CTL_GO && count == '0) |=> (ctrl == '0));
endmodule

// File: rtl/cfgdma_mover.sv
module cfgdma_mover
    import cfgdma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic last,
    input  logic mem_ack,
    input  logic mem_err,
    output logic busy,
    output logic step,
    output logic fail
);
    typedef enum logic {MV_IDLE, MV_COPY} mv_state_e;
    mv_state_e state;

    assign busy = (state == MV_COPY);
    assign fail = busy && mem_err;
    assign step = busy && mem_ack && !mem_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MV_IDLE;
        end else begin
            case (state)
                MV_IDLE: if (start) state <= MV_COPY;
                default: if (fail || (step && last)) state <= MV_IDLE;
            endcase
        end
    end

    p_hold_req_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack && !mem_err) |=> busy);

    p_stop_on_err_r8: assert property (@(posedge clk) disable iff (rst)
        fail |=> !busy);
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic [LANES-1:0]  bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [7:0]        src_data,
    output logic              src_take,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err
);
    reg_wr_t           wr;
    logic [ADDR_W-1:0] dst;
    logic [LEN_W-1:0]  count;
    logic [CTL_W-1:0]  ctrl;
    logic              start, last, busy, step, fail;

    cfgdma_bus_decode u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_off   (bus_off),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .dst       (dst),
        .count     (count),
        .ctrl      (ctrl),
        .wr        (wr),
        .bus_rdata (bus_rdata)
    );

    cfgdma_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .busy  (busy),
        .step  (step),
        .fail  (fail),
        .dst   (dst),
        .count (count),
        .ctrl  (ctrl),
        .start (start),
        .last  (last)
    );

    cfgdma_mover u_mover (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .last    (last),
        .mem_ack (mem_ack),
        .mem_err (mem_err),
        .busy    (busy),
        .step    (step),
        .fail    (fail)
    );

    assign mem_req   = busy;
    assign mem_addr  = dst;
    assign mem_wdata = src_data;
    assign src_take  = step;

    p_run_status_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (ctrl == CTL_GO));

    p_count_live_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (count != '0));

    p_err_no_copy_r11: assert property (@(posedge clk) disable iff (rst)
        ctrl[CTL_ERR_BIT] |-> !mem_req);
endmodule

// File: tb/cfgdma_engine_test.sv
`timescale 1ns/1ps
module cfgdma_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_off = '0, bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  src_data;
    logic        src_take, mem_req, mem_ack = 1'b0, mem_err = 1'b0;
    logic [63:0] mem_addr;
    logic [7:0]  mem_wdata;

    int n_chk = 0, n_err = 0;
    logic [63:0] m_addr;
    logic [31:0] m_len;
    logic [1:0]  m_ctl;
    bit          m_busy = 0;
    int          src_cnt = 0;
    int          gap = 0, wcnt = 0;
    logic [63:0] err_lim = 64'hFFFF_FFFF_FFFF_FFFF;

    always #2.5 clk = ~clk;

    cfgdma_engine uut (.*);

    function automatic logic [7:0] pat(input int n);
        return 8'(n * 7 + 3);
    endfunction
    function automatic logic [31:0] bsw(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    assign src_data = pat(src_cnt);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // reference model
    always @(posedge clk) begin
        logic [31:0] v;
        if (rst) begin
            m_addr = '0; m_len = '0; m_ctl = '0; m_busy = 0; src_cnt = 0;
        end else if (m_busy) begin
            if (mem_err) begin
                m_ctl = 2'b11; m_busy = 0;
            end else if (mem_ack) begin
                m_addr = m_addr + 1; m_len = m_len - 1; src_cnt++;
                if (m_len == 0) begin m_ctl = 0; m_busy = 0; end
            end
        end else if (bus_valid && bus_write && bus_off[1:0] == 0 && bus_be == 4'hF) begin
            v = bsw(bus_wdata);
            case (bus_off[3:2])
                2'd0: m_addr[31:0]  = v;
                2'd1: m_addr[63:32] = v;
                2'd2: m_len = v;
                default: begin
                    if (v[1:0] == 2'b10 && m_len != 0) begin m_ctl = 2'b10; m_busy = 1; end
                    else if (v[1:0] == 2'b10) m_ctl = 0;
                    else m_ctl = v[1:0];
                end
            endcase
        end
    end

    // memory responder
    always @(negedge clk) begin
        if (mem_req) begin
            if (mem_addr >= err_lim) begin mem_err = 1; mem_ack = 0; end
            else if (wcnt >= gap) begin mem_err = 0; mem_ack = 1; wcnt = 0; end
            else begin mem_err = 0; mem_ack = 0; wcnt++; end
        end else begin
            mem_ack = 0; mem_err = 0; wcnt = 0;
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            chk(mem_req == m_busy, "R6 mem_req", 64'(mem_req), 64'(m_busy));
            if (m_busy) chk(mem_addr == m_addr, "R6 mem_addr", mem_addr, m_addr);
            if (m_busy && mem_ack && !mem_err) begin
                chk(src_take == 1'b1, "R6 src_take", 64'(src_take), 64'd1);
                chk(mem_wdata == pat(src_cnt), "R6 mem_wdata", 64'(mem_wdata), 64'(pat(src_cnt)));
            end else begin
                chk(src_take == 1'b0, "R6 src_take idle", 64'(src_take), 64'd0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    task automatic wr(input logic [3:0] off, input logic [31:0] data, input logic [3:0] be);
        bus_valid = 1; bus_write = 1; bus_off = off; bus_be = be; bus_wdata = data;
        @(posedge clk); @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic wv(input logic [3:0] off, input logic [31:0] val);
        wr(off, bsw(val), 4'hF);
    endtask

    function automatic logic [31:0] mval(input logic [3:0] off);
        case (off[3:2])
            2'd0: return m_addr[31:0];
            2'd1: return m_addr[63:32];
            2'd2: return m_len;
            default: return {30'd0, m_ctl};
        endcase
    endfunction

    task automatic rd(input logic [3:0] off, input logic [3:0] be, input logic [31:0] exp, input string tag);
        bus_valid = 1; bus_write = 0; bus_off = off; bus_be = be;
        #0.5;
        chk(bus_rdata == exp, tag, 64'(bus_rdata), 64'(exp));
        bus_valid = 0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (mem_req && guard < 2000) begin @(negedge clk); guard++; end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 4; i++) rd(4'(4 * i), 4'hF, 32'h0, "R1 reset reg");
        chk(mem_req == 0, "R1 mem_req", 64'(mem_req), 0);

        // R4 address halves
        wv(0, 32'h1000_0000); wv(4, 32'h0000_0001);
        rd(0, 4'hF, bsw(32'h1000_0000), "R4 lo readback");
        rd(4, 4'hF, bsw(32'h0000_0001), "R4 hi readback");
        wv(0, 32'h1000_0040);
        rd(4, 4'hF, bsw(32'h0000_0001), "R4 hi kept");
        rd(0, 4'hF, bsw(32'h1000_0040), "R4 lo new");

        // R2 rejected accesses
        wr(1, 32'hAAAA_AAAA, 4'hF);
        wr(0, 32'hBBBB_BBBB, 4'h3);
        rd(0, 4'hF, bsw(32'h1000_0040), "R2 bad write ignored");
        rd(0, 4'h7, 32'h0, "R2 partial read zero");
        rd(2, 4'hF, 32'h0, "R2 unaligned read zero");

        // R3 endianness: raw bus word sets length 3
        wr(8, 32'h0300_0000, 4'hF);
        rd(8, 4'hF, 32'h0300_0000, "R3 raw length");
        chk(m_len == 3, "R3 model length", 64'(m_len), 3);
        wv(12, 32'h2);
        wait_idle();
        rd(0, 4'hF, bsw(32'h1000_0043), "R3 R7 three bytes moved");
        rd(8, 4'hF, 32'h0, "R7 length zero");
        rd(12, 4'hF, 32'h0, "R7 control cleared");

        // R9 slow copy, reads and ignored writes while busy
        gap = 3;
        wv(8, 6);
        wv(12, 32'h2);
        repeat (2) @(negedge clk);
        rd(12, 4'hF, bsw(32'h2), "R9 busy status");
        wv(8, 32'h55);
        wv(0, 32'h0);
        wv(12, 32'h0);
        rd(12, 4'hF, bsw(32'h2), "R9 control write ignored");
        wait_idle();
        rd(8, 4'hF, 32'h0, "R9 R7 length after busy writes");
        rd(0, 4'hF, bsw(32'h1000_0049), "R9 address after busy writes");
        gap = 0;

        // R8 error mid-copy
        wv(4, 0); wv(0, 32'h1FFD); wv(8, 8);
        err_lim = 64'h2000;
        wv(12, 32'h2);
        wait_idle();
        rd(12, 4'hF, bsw(32'h3), "R8 error status");
        rd(0, 4'hF, bsw(32'h2000), "R8 address frozen");
        rd(8, 4'hF, bsw(32'h5), "R8 length frozen");

        // R11 error-bit values start nothing
        wv(12, 32'h3);
        @(negedge clk);
        chk(mem_req == 0, "R11 no start on 3", 64'(mem_req), 0);
        rd(12, 4'hF, bsw(32'h3), "R11 held 3");
        wv(12, 32'h1);
        @(negedge clk);
        chk(mem_req == 0, "R11 no start on 1", 64'(mem_req), 0);
        rd(12, 4'hF, bsw(32'h1), "R11 held 1");

        // R5 masking, resume after error
        wv(12, 32'h5);
        rd(12, 4'hF, bsw(32'h1), "R5 masked to 1");
        err_lim = 64'hFFFF_FFFF_FFFF_FFFF;
        wv(12, 32'hFFFF_FFFE);
        chk(mem_req == 1, "R5 masked start", 64'(mem_req), 1);
        wait_idle();
        rd(0, 4'hF, bsw(32'h2005), "R5 resumed address");
        rd(12, 4'hF, 32'h0, "R7 resumed done");

        // R10 zero length start
        wv(8, 0);
        wv(12, 32'h2);
        chk(mem_req == 0, "R10 no request", 64'(mem_req), 0);
        rd(12, 4'hF, 32'h0, "R10 control zero");
        repeat (3) @(negedge clk);
        chk(mem_req == 0, "R10 stays idle", 64'(mem_req), 0);

        // error on the first byte with high half set
        wv(4, 32'h0000_0002); wv(0, 32'h0); wv(8, 4);
        err_lim = 64'h0000_0002_0000_0000;
        wv(12, 32'h2);
        wait_idle();
        rd(8, 4'hF, bsw(32'h4), "R8 nothing moved");
        rd(4, 4'hF, bsw(32'h2), "R4 R8 hi kept");
        report();
    end
endmodule